// File: doc/BRIEF.md
# Ageing-Counter Frame Replacement Selector

This block picks which physical page frame receives the next page brought in on a fault. It keeps one resident flag and one small age counter for each frame. A periodic tick makes every resident frame older by one step. A reference to a frame makes it young again by clearing its counter. Allocation and release updates from the fault handler keep the resident set current.

When the handler raises a select request, the block answers one cycle later with a frame index and a valid pulse.

- If any frame is empty, the lowest-numbered empty frame is returned.
- Otherwise the oldest resident frame is returned, which approximates the least recently used one.
- When the returned frame holds a page whose per-frame dirty input is set, a write-back flag tells the handler to save that page before the frame is overwritten.

Transfers to backing store and page-table maintenance belong to other blocks.

Top module: `lru_frame_replacer`

## Requirements
- R1: After synchronous reset no frame is resident, every age counter is zero and the valid output is low.
- R2: On a cycle with the tick input high, the age of each resident frame that receives no other update rises by exactly one; the age of a frame that is not resident stays zero.
- R3: A reference to a frame clears its age to zero, also when a tick arrives in the same cycle.
- R4: Ages are 8 bits wide and saturate at 255 instead of wrapping.
- R5: If at least one frame is not resident, the selection is the lowest-numbered non-resident frame.
- R6: If every frame is resident, the selection is the frame with the largest age, and on a tie the lowest-numbered of the tied frames.
- R7: The write-back output equals the dirty input bit of the selected frame when that frame is resident, and is 0 when an empty frame is selected.
- R8: A select request in one cycle gives valid high in the next cycle, together with the frame index and write-back flag. These reflect the state and dirty inputs present when the request was made. Valid is low in every cycle that does not follow a request.
- R9: Allocating a frame makes it resident with age zero. Releasing a frame makes it non-resident with age zero. If both target the same frame in one cycle, the release wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Periodic ageing pulse |
| ref_valid_i | input | 1 | A frame was referenced |
| ref_frame_i | input | 5 | Index of the referenced frame |
| alloc_valid_i | input | 1 | A frame was filled with a page |
| alloc_frame_i | input | 5 | Index of the filled frame |
| free_valid_i | input | 1 | A frame was released |
| free_frame_i | input | 5 | Index of the released frame |
| dirty_i | input | 32 | Changed flag of each frame, bit n for frame n |
| select_i | input | 1 | Request a replacement choice |
| victim_valid_o | output | 1 | Choice is valid this cycle |
| victim_frame_o | output | 5 | Chosen frame index |
| victim_writeback_o | output | 1 | Chosen frame must be written back first |

## Verification
The hardest cases to reach are those where every frame is resident and several counters share the highest value, most of all the saturated value. Reaching them takes hundreds of ticks with no reference to the tied frames. The stimulus first fills the frames one at a time and asks for a choice after each fill. It then runs long stretches of ticks past 255, and after that clears single counters with references timed to land on ticks. Its last phase is a pseudo-random phase that mixes ticks, references, releases and fills while a bench model keeps the expected ages.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

    localparam int FRAMES_DEF = 32;
    localparam int AGE_W_DEF  = 8;

    typedef enum logic {
        PICK_EMPTY = 1'b0,
        PICK_OLDEST = 1'b1
    } pick_src_e;

    function automatic logic [AGE_W_DEF-1:0] age_step(input logic [AGE_W_DEF-1:0] a);
        return (a == {AGE_W_DEF{1'b1}}) ? a : a + 1'b1;
    endfunction

endpackage

// File: rtl/lru_age_cell.sv
module lru_age_cell #(
    parameter int AGE_W = lru_age_pkg::AGE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             touch_i,
    input  logic             fill_i,
    input  logic             evict_i,
    output logic             resident_o,
    output logic [AGE_W-1:0] age_o
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            resident_o <= 1'b0;
            age_o      <= '0;
        end else if (evict_i) begin
            resident_o <= 1'b0;
            age_o      <= '0;
        end else if (fill_i) begin
            resident_o <= 1'b1;
            age_o      <= '0;
        end else if (touch_i) begin
            age_o      <= '0;
        end else if (tick_i && resident_o && (age_o != AGE_MAX)) begin
            age_o      <= age_o + 1'b1;
        end
    end

    // R2: one step per tick while resident and untouched
    p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && resident_o && !touch_i && !fill_i && !evict_i && age_o != AGE_MAX)
        |=> (age_o == AGE_W'($past(age_o) + 1'b1)));

    // R2: empty frames hold a zero age
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !resident_o |-> (age_o == '0));

    // R3: a reference clears the age even on a tick
    p_touch_zero_r3: assert property (@(posedge clk) disable iff (rst)
        touch_i |=> (age_o == '0));

    // R4: saturated counters stay saturated
    p_saturate_r4: assert property (@(posedge clk) disable iff (rst)
        (age_o == AGE_MAX && !touch_i && !fill_i && !evict_i) |=> (age_o == AGE_MAX));

    // R9: fill and release outcomes
    p_fill_r9: assert property (@(posedge clk) disable iff (rst)
        (fill_i && !evict_i) |=> (resident_o && age_o == '0));
    p_evict_r9: assert property (@(posedge clk) disable iff (rst)
        evict_i |=> !resident_o);

endmodule

// File: rtl/lru_age_bank.sv
module lru_age_bank #(
    parameter int FRAMES = lru_age_pkg::FRAMES_DEF,
    parameter int AGE_W  = lru_age_pkg::AGE_W_DEF,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             touch_v_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    input  logic             fill_v_i,
    input  logic [IDX_W-1:0] fill_idx_i,
    input  logic             evict_v_i,
    input  logic [IDX_W-1:0] evict_idx_i,
    output logic [FRAMES-1:0] resident_o,
    output logic [AGE_W-1:0]  ages_o [FRAMES]
);

    for (genvar g = 0; g < FRAMES; g++) begin : g_cell
        logic hit_touch, hit_fill, hit_evict;
        assign hit_touch = touch_v_i && (touch_idx_i == IDX_W'(g));
        assign hit_fill  = fill_v_i  && (fill_idx_i  == IDX_W'(g));
        assign hit_evict = evict_v_i && (evict_idx_i == IDX_W'(g));

        lru_age_cell #(.AGE_W(AGE_W)) u_cell (
            .clk        (clk),
            .rst        (rst),
            .tick_i     (tick_i),
            .touch_i    (hit_touch),
            .fill_i     (hit_fill),
            .evict_i    (hit_evict),
            .resident_o (resident_o[g]),
            .age_o      (ages_o[g])
        );
    end

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
    import lru_age_pkg::*;
#(
    parameter int FRAMES = lru_age_pkg::FRAMES_DEF,
    parameter int AGE_W  = lru_age_pkg::AGE_W_DEF,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic [FRAMES-1:0] resident_i,
    input  logic [AGE_W-1:0]  ages_i [FRAMES],
    output logic [IDX_W-1:0]  idx_o,
    output pick_src_e         src_o
);
    logic             empty_found;
    logic [IDX_W-1:0] empty_idx;
    logic             old_found;
    logic [IDX_W-1:0] old_idx;
    logic [AGE_W-1:0] old_age;

    always_comb begin
        empty_found = 1'b0;
        empty_idx   = '0;
        for (int i = 0; i < FRAMES; i++) begin
            if (!resident_i[i] && !empty_found) begin
                empty_found = 1'b1;
                empty_idx   = IDX_W'(i);
            end
        end
    end

    // strict greater-than keeps the lowest index among equal ages
    always_comb begin
        old_found = 1'b0;
        old_idx   = '0;
        old_age   = '0;
        for (int i = 0; i < FRAMES; i++) begin
            if (resident_i[i] && (!old_found || ages_i[i] > old_age)) begin
                old_found = 1'b1;
                old_idx   = IDX_W'(i);
                old_age   = ages_i[i];
            end
        end
    end

    always_comb begin
        if (empty_found) begin
            idx_o = empty_idx;
            src_o = PICK_EMPTY;
        end else begin
            idx_o = old_idx;
            src_o = PICK_OLDEST;
        end
    end

endmodule

// File: rtl/lru_frame_replacer.sv
module lru_frame_replacer
    import lru_age_pkg::*;
#(
    parameter int FRAMES = lru_age_pkg::FRAMES_DEF,
    parameter int AGE_W  = lru_age_pkg::AGE_W_DEF,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              ref_valid_i,
    input  logic [IDX_W-1:0]  ref_frame_i,
    input  logic              alloc_valid_i,
    input  logic [IDX_W-1:0]  alloc_frame_i,
    input  logic              free_valid_i,
    input  logic [IDX_W-1:0]  free_frame_i,
    input  logic [FRAMES-1:0] dirty_i,
    input  logic              select_i,
    output logic              victim_valid_o,
    output logic [IDX_W-1:0]  victim_frame_o,
    output logic              victim_writeback_o
);
    logic [FRAMES-1:0] resident;
    logic [AGE_W-1:0]  ages [FRAMES];
    logic [IDX_W-1:0]  pick_idx;
    pick_src_e         pick_src;

    lru_age_bank #(.FRAMES(FRAMES), .AGE_W(AGE_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .touch_v_i   (ref_valid_i),
        .touch_idx_i (ref_frame_i),
        .fill_v_i    (alloc_valid_i),
        .fill_idx_i  (alloc_frame_i),
        .evict_v_i   (free_valid_i),
        .evict_idx_i (free_frame_i),
        .resident_o  (resident),
        .ages_o      (ages)
    );

    lru_victim_pick #(.FRAMES(FRAMES), .AGE_W(AGE_W)) u_pick (
        .resident_i (resident),
        .ages_i     (ages),
        .idx_o      (pick_idx),
        .src_o      (pick_src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_valid_o     <= 1'b0;
            victim_frame_o     <= '0;
            victim_writeback_o <= 1'b0;
        end else begin
            victim_valid_o <= select_i;
            if (select_i) begin
                victim_frame_o     <= pick_idx;
                victim_writeback_o <= (pick_src == PICK_OLDEST) && dirty_i[pick_idx];
            end
        end
    end

    // R8: one-cycle response pulse
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
        select_i |=> victim_valid_o);
    p_valid_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !select_i |=> !victim_valid_o);

    // R5: an empty frame is offered whenever one exists, never needing write-back
    p_empty_first_r5: assert property (@(posedge clk) disable iff (rst)
        (select_i && !(&resident)) |=> (!resident[victim_frame_o] || !victim_writeback_o));
    p_empty_clean_r7: assert property (@(posedge clk) disable iff (rst)
        (select_i && !resident[pick_idx]) |=> !victim_writeback_o);

    // R7: dirty resident choice must flag write-back
    p_dirty_wb_r7: assert property (@(posedge clk) disable iff (rst)
        (select_i && resident[pick_idx] && dirty_i[pick_idx]) |=> victim_writeback_o);

endmodule

// File: tb/lru_frame_replacer_test.sv
`timescale 1ns/1ps
module lru_frame_replacer_test;
    localparam int N = 32;
    localparam int AMAX = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 0, rv = 0, av = 0, fv = 0, sel = 0;
    logic [4:0] ri = 0, ai = 0, fi = 0;
    logic [N-1:0] dirty = '0;
    logic vv, vwb;
    logic [4:0] vf;

    int checks = 0;
    int failures = 0;
    int m_age [N];
    bit m_res [N];
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    lru_frame_replacer uut (
        .clk(clk), .rst(rst), .tick_i(tick),
        .ref_valid_i(rv), .ref_frame_i(ri),
        .alloc_valid_i(av), .alloc_frame_i(ai),
        .free_valid_i(fv), .free_frame_i(fi),
        .dirty_i(dirty), .select_i(sel),
        .victim_valid_o(vv), .victim_frame_o(vf), .victim_writeback_o(vwb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_pick(output int f, output int wb);
        f = -1;
        for (int i = 0; i < N; i++)
            if (!m_res[i] && f < 0) f = i;
        if (f >= 0) begin
            wb = 0;
            return;
        end
        f = 0;
        for (int i = 1; i < N; i++)
            if (m_age[i] > m_age[f]) f = i;
        wb = dirty[f] ? 1 : 0;
    endfunction

    function automatic void model_step(bit t, bit r, int rf, bit a, int af, bit fr, int ff);
        for (int i = 0; i < N; i++) begin
            if (fr && ff == i) begin
                m_res[i] = 0; m_age[i] = 0;
            end else if (a && af == i) begin
                m_res[i] = 1; m_age[i] = 0;
            end else if (r && rf == i) begin
                m_age[i] = 0;
            end else if (t && m_res[i] && m_age[i] < AMAX) begin
                m_age[i]++;
            end
        end
    endfunction

    task automatic cyc(bit t, bit r, int rf, bit a, int af, bit fr, int ff, bit s, string req);
        int ef, ewb;
        @(negedge clk);
        tick = t; rv = r; ri = 5'(rf); av = a; ai = 5'(af);
        fv = fr; fi = 5'(ff); sel = s;
        model_pick(ef, ewb);
        @(posedge clk);
        model_step(t, r, rf, a, af, fr, ff);
        #1;
        if (s) begin
            chk({req, " valid"}, int'(vv), 1);
            chk({req, " frame"}, int'(vf), ef);
            chk({req, " writeback"}, int'(vwb), ewb);
        end
    endtask

    task automatic pick(string req);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, req);
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected=0", wd);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_age[i] = 0;
            m_res[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 valid after reset", int'(vv), 0);
        chk("R1 writeback after reset", int'(vwb), 0);

        // R5 and R7: empty set gives frame 0 with no write-back even when dirty
        dirty = '1;
        pick("R5 all empty");
        chk("R7 empty frame clean", int'(vwb), 0);

        // R8: valid drops the cycle after a lone request
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8");
        chk("R8 valid quiet", int'(vv), 0);

        // R5, R6: fill frames one at a time, ask after each fill
        dirty = 32'hA5A5_5A5A;
        for (int k = 0; k < N; k++) begin
            cyc(1, 0, 0, 1, k, 0, 0, 0, "R9");
            pick(k < N - 1 ? "R5 sweep" : "R6 full set");
        end

        // R2, R3, R6: ageing with a rotating reference
        for (int j = 0; j < N; j++) begin
            cyc(1, 1, j, 0, 0, 0, 0, 0, "R3");
            cyc(1, 0, 0, 0, 0, 0, 0, 1, "R2 age order");
        end

        // R4: run past saturation, all tied
        for (int j = 0; j < 300; j++) cyc(1, 0, 0, 0, 0, 0, 0, 0, "R4");
        pick("R4 saturated tie");
        chk("R6 tie lowest", int'(vf), 0);
        cyc(1, 1, 0, 0, 0, 0, 0, 0, "R3");
        pick("R3 ref with tick");
        chk("R4 next saturated", int'(vf), 1);

        // R7: dirty follows the choice
        for (int j = 0; j < 6; j++) begin
            cyc(0, 1, j + 1, 0, 0, 0, 0, 0, "R7");
            pick("R7 writeback");
        end

        // R9: release wins over allocation on the same frame
        cyc(0, 0, 0, 1, 20, 1, 20, 0, "R9");
        pick("R9 release wins");
        chk("R9 released frame chosen", int'(vf), 20);
        cyc(0, 0, 0, 1, 20, 0, 0, 1, "R9 refill");

        // mixed pseudo-random traffic
        for (int j = 0; j < 3000; j++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            dirty = {dirty[30:0], lf[0] ^ dirty[31]};
            cyc(lf[1] | lf[2], lf[3], int'(lf[8:4]), lf[9] & lf[10], int'(lf[15:11]),
                lf[11] & lf[12] & lf[13], int'(lf[7:3]), lf[14] | lf[0], "R6 mixed");
        end

        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule